// File: doc/BRIEF.md
# Strobed Dot-Matrix Refresh Controller

This block refreshes a serial-input LED dot-matrix module that holds four characters, each a 5-wide by 7-high array. The refresh walks the five columns one after another. For each column the controller first makes a generated shift clock and sends the 28 row bits for that column over one serial data line. The 28 bits are seven rows for each of the four characters, and the character furthest down the chain goes first. While those bits shift in, every column drive stays off. When the load is complete, the controller enables only that column's drive for a programmed number of system cycles and then moves on to the next column.

Row patterns come from a parallel frame image. It holds one byte per column per character, and the low seven bits of each byte are the rows. The controller copies the image only at the start of a frame, so a frame never shows a mix of old and new content. A single-cycle frame marker flags that point.

A separate output drives the module's blanking input. It is either a pulse-width-modulated brightness signal or constant high for full intensity. Parameters set the shift-clock division, the column on-time and the brightness period and duty. Elaboration rejects any set of parameters that breaks the module's timing limits: shift clock above 5 MHz, a clock phase shorter than 75 ns, a column period over 2 ms, or a brightness rate above 50 kHz.

Top module: `dmx_refresh_ctrl`

## Requirements
- R1: While rst_n is low, sclk, sdata, col_en, blank and frame_start are all low. After rst_n is released, the sequence starts again with a frame marker followed by the column 1 phase.
- R2: Every column phase gives exactly NUM_CHARS*ROWS (28) rising edges on sclk while col_en is all-zero, and only then enables the column. While any column is enabled, sclk stays low.
- R3: During the phase for column k (0 = column 1), the character with the highest index (character four) is sent first and character one last. Within each character, row bit ROWS-1 goes first and row bit 0 last. The bit for character c (0 = character one), column k, row r is fb_data[(c*COLS+k)*8 + r]. Bit 7 of each byte is not used.
- R4: sdata changes only while sclk is low and holds its value through every sclk high phase. This gives at least SCLK_HALF system cycles of setup and hold around each rising edge.
- R5: Each sclk high phase lasts exactly SCLK_HALF system cycles. Each low phase between two rising edges inside a load also lasts exactly SCLK_HALF cycles.
- R6: col_en bit k drives column k+1. Columns are enabled one at a time in the order 1, 2, 3, 4, 5, 1, ... and col_en goes back to all-zero between phases.
- R7: Each enabled column stays on for exactly ON_CYCLES system cycles.
- R8: frame_start is high for exactly one cycle, in the first cycle of the column 1 load, with no column enabled. fb_data is captured only at that clock edge. A change to fb_data at any other time has no effect on the serial data until the next frame.
- R9: When PWM_HIGH < PWM_PERIOD, blank repeats with a period of PWM_PERIOD cycles and is high for PWM_HIGH cycles of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_data | input | NUM_CHARS*COLS*8 | Frame image: one byte per character per column, low ROWS bits are rows |
| sclk | output | 1 | Generated shift clock for the module's shift register |
| sdata | output | 1 | Serial row data, updated while sclk is low |
| col_en | output | COLS | One-hot column drive enables |
| blank | output | 1 | Brightness/blanking output (PWM or constant high) |
| frame_start | output | 1 | Single-cycle marker at the start of the column 1 load |

## Verification
Corrupting the bit counter or the character order shows up at the end of the very next load. The 28-bit image the bench captures on sclk rising edges no longer matches the expected column, or the column switches on after too few or too many edges. A column counter or on-timer in the wrong state appears within one column period as a column out of order, two enables at once, or an on-time of the wrong length. A frame latch that tears appears as mid-frame serial content that follows the new image before the next frame marker. The brightness counter is checked over whole periods, so a wrong wrap or threshold shows up as the wrong high or low length within one PWM period.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_ON   = 2'd2
   } phase_t;

endpackage

// File: rtl/dmx_shift_engine.sv
// Serializer timing: generates the shift clock and walks the bit index.
// Data index advances only on the falling edge of the generated clock.
module dmx_shift_engine #(
   parameter int unsigned HALF  = 10,
   parameter int unsigned NBITS = 28
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   output logic                       sclk,
   output logic                       busy,
   output logic [$clog2(NBITS)-1:0]   bit_idx,
   output logic                       done
);

   localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int unsigned BIT_W = $clog2(NBITS);

   logic [DIV_W-1:0] div_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         div_cnt <= '0;
         bit_idx <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               div_cnt <= '0;
               bit_idx <= '0;
            end
         end else if (div_cnt != DIV_W'(HALF - 1)) begin
            div_cnt <= div_cnt + 1'b1;
         end else begin
            div_cnt <= '0;
            if (!sclk) begin
               sclk <= 1'b1;
            end else begin
               sclk <= 1'b0;
               if (bit_idx == BIT_W'(NBITS - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_idx <= bit_idx + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dmx_row_select.sv
// Maps (column, bit index) onto the latched frame: far character first,
// top row bit first inside each character. Pure wiring plus one mux.
module dmx_row_select #(
   parameter int unsigned NUM_CHARS = 4,
   parameter int unsigned ROWS      = 7,
   parameter int unsigned COLS      = 5
) (
   input  logic [NUM_CHARS*COLS-1:0][ROWS-1:0]  frame,
   input  logic [$clog2(COLS)-1:0]              col,
   input  logic [$clog2(NUM_CHARS*ROWS)-1:0]    bit_idx,
   input  logic                                 active,
   output logic                                 sdata
);

   localparam int unsigned NBITS = NUM_CHARS * ROWS;

   logic [COLS-1:0][NBITS-1:0] stream;

   for (genvar k = 0; k < COLS; k++) begin : g_col
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         assign stream[k][i] =
            frame[(NUM_CHARS - 1 - i / ROWS) * COLS + k][ROWS - 1 - i % ROWS];
      end
   end

   assign sdata = active & stream[col][bit_idx];

endmodule

// File: rtl/dmx_blank_pwm.sv
// Brightness output: free-running PWM, or a constant-high variant.
module dmx_blank_pwm #(
   parameter int unsigned PERIOD = 2000,
   parameter int unsigned HIGH   = 1500
) (
   input  logic clk,
   input  logic rst_n,
   output logic blank
);

   if (HIGH >= PERIOD) begin : g_full
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) blank <= 1'b0;
         else        blank <= 1'b1;
      end
   end else begin : g_pwm
      localparam int unsigned CNT_W = $clog2(PERIOD);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt   <= '0;
            blank <= 1'b0;
         end else begin
            blank <= (cnt < CNT_W'(HIGH));
            cnt   <= (cnt == CNT_W'(PERIOD - 1)) ? '0 : cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dmx_refresh_ctrl.sv
module dmx_refresh_ctrl
   import dmx_pkg::*;
#(
   parameter int unsigned NUM_CHARS  = 4,
   parameter int unsigned ROWS       = 7,
   parameter int unsigned COLS       = 5,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned SYS_CLK_HZ = 100_000_000,
   parameter int unsigned SCLK_HALF  = 10,
   parameter int unsigned ON_CYCLES  = 1000,
   parameter int unsigned PWM_PERIOD = 2000,
   parameter int unsigned PWM_HIGH   = 1500
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_CHARS*COLS*BYTE_W-1:0]  fb_data,
   output logic                              sclk,
   output logic                              sdata,
   output logic [COLS-1:0]                   col_en,
   output logic                              blank,
   output logic                              frame_start
);

   localparam int unsigned NBITS    = NUM_CHARS * ROWS;
   localparam int unsigned NSLOT    = NUM_CHARS * COLS;
   localparam int unsigned COL_W    = $clog2(COLS);
   localparam int unsigned BIT_W    = $clog2(NBITS);
   localparam int unsigned ON_W     = $clog2(ON_CYCLES + 1);
   localparam int unsigned LOAD_CYC = 2 * SCLK_HALF * NBITS + 3;

   localparam longint unsigned CLK_L  = 64'(SYS_CLK_HZ);
   localparam longint unsigned HALF_L = 64'(SCLK_HALF);
   localparam longint unsigned COLP_L = 64'(LOAD_CYC) + 64'(ON_CYCLES);

   // Elaboration-time parameter checks
   if (ROWS > BYTE_W || ROWS < 1) begin : g_err_rows
      $error("ROWS must fit in one frame byte");
   end
   if (COLS < 2) begin : g_err_cols
      $error("COLS must be at least 2");
   end
   if (NBITS < 2) begin : g_err_bits
      $error("chain must hold at least two bits");
   end
   if (SCLK_HALF < 1 || ON_CYCLES < 1) begin : g_err_zero
      $error("SCLK_HALF and ON_CYCLES must be nonzero");
   end
   if (CLK_L > 64'd10_000_000 * HALF_L) begin : g_err_sclk_rate
      $error("shift clock would exceed 5 MHz");
   end
   if (HALF_L * 64'd1_000_000_000 < 64'd75 * CLK_L) begin : g_err_sclk_phase
      $error("shift clock phase shorter than 75 ns");
   end
   if (COLP_L * 64'd1000 > 64'd2 * CLK_L) begin : g_err_refresh
      $error("column period exceeds 2 ms");
   end
   if (PWM_HIGH < PWM_PERIOD &&
       (PWM_PERIOD < 2 || CLK_L > 64'd50_000 * 64'(PWM_PERIOD))) begin : g_err_pwm
      $error("brightness PWM faster than 50 kHz");
   end

   // Frame image: keep only the row bits of each byte
   logic [NSLOT-1:0][ROWS-1:0] fb_rows;
   logic [NSLOT-1:0][ROWS-1:0] fb_q;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign fb_rows[s] = fb_data[s*BYTE_W +: ROWS];
   end

   if (BYTE_W > ROWS) begin : g_pad
      logic [NSLOT*(BYTE_W-ROWS)-1:0] unused_pad_bits;
      for (genvar s = 0; s < NSLOT; s++) begin : g_pad_slot
         assign unused_pad_bits[s*(BYTE_W-ROWS) +: (BYTE_W-ROWS)] =
            fb_data[s*BYTE_W + ROWS +: (BYTE_W-ROWS)];
      end
   end

   phase_t              phase;
   logic [COL_W-1:0]    col;
   logic [ON_W-1:0]     on_cnt;
   logic                start_q;
   logic                eng_busy;
   logic                eng_done;
   logic [BIT_W-1:0]    bit_idx;

   dmx_shift_engine #(
      .HALF  (SCLK_HALF),
      .NBITS (NBITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_q),
      .sclk    (sclk),
      .busy    (eng_busy),
      .bit_idx (bit_idx),
      .done    (eng_done)
   );

   dmx_row_select #(
      .NUM_CHARS (NUM_CHARS),
      .ROWS      (ROWS),
      .COLS      (COLS)
   ) u_rows (
      .frame   (fb_q),
      .col     (col),
      .bit_idx (bit_idx),
      .active  (eng_busy),
      .sdata   (sdata)
   );

   dmx_blank_pwm #(
      .PERIOD (PWM_PERIOD),
      .HIGH   (PWM_HIGH)
   ) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .blank (blank)
   );

   // Column sequencer: load, strobe, advance; frame latch at column 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         col         <= '0;
         on_cnt      <= '0;
         start_q     <= 1'b0;
         frame_start <= 1'b0;
         col_en      <= '0;
         fb_q        <= '0;
      end else begin
         start_q     <= 1'b0;
         frame_start <= 1'b0;
         case (phase)
            PH_IDLE: begin
               phase       <= PH_LOAD;
               col         <= '0;
               fb_q        <= fb_rows;
               frame_start <= 1'b1;
               start_q     <= 1'b1;
            end
            PH_LOAD: begin
               if (eng_done) begin
                  phase  <= PH_ON;
                  on_cnt <= '0;
                  col_en <= COLS'(1) << col;
               end
            end
            PH_ON: begin
               if (on_cnt == ON_W'(ON_CYCLES - 1)) begin
                  col_en  <= '0;
                  phase   <= PH_LOAD;
                  start_q <= 1'b1;
                  if (col == COL_W'(COLS - 1)) begin
                     col         <= '0;
                     fb_q        <= fb_rows;
                     frame_start <= 1'b1;
                  end else begin
                     col <= col + 1'b1;
                  end
               end else begin
                  on_cnt <= on_cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dmx_refresh_ctrl_chk.sv
module dmx_refresh_ctrl_chk #(
   parameter int unsigned COLS      = 5,
   parameter int unsigned SCLK_HALF = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sclk,
   input logic            sdata,
   input logic [COLS-1:0] col_en,
   input logic            frame_start
);

   logic [15:0]     hi_run;
   logic [COLS-1:0] last_col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run   <= '0;
         last_col <= COLS'(1) << (COLS - 1);
      end else begin
         hi_run <= sclk ? hi_run + 16'd1 : 16'd0;
         if (col_en != '0) last_col <= col_en;
      end
   end

   a_r2_dark_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> (col_en == '0));

   a_r6_single_column: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_en));

   a_r6_column_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|col_en) |-> (col_en == {last_col[COLS-2:0], last_col[COLS-1]}));

   a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdata));

   a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_run == 16'(SCLK_HALF)));

   a_r8_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   a_r8_frame_dark: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (col_en == '0 && !sclk));

endmodule

bind dmx_refresh_ctrl dmx_refresh_ctrl_chk #(
   .COLS      (COLS),
   .SCLK_HALF (SCLK_HALF)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sclk        (sclk),
   .sdata       (sdata),
   .col_en      (col_en),
   .frame_start (frame_start)
);

// File: tb/dmx_refresh_ctrl_tb.sv
module dmx_refresh_ctrl_tb;

   localparam int NC    = 4;
   localparam int ROWS  = 7;
   localparam int COLS  = 5;
   localparam int HALF  = 10;
   localparam int ONC   = 1000;
   localparam int PP    = 2000;
   localparam int PH    = 1500;
   localparam int NBITS = NC * ROWS;
   localparam int FB_W  = NC * COLS * 8;

   logic            clk;
   logic            rst_n;
   logic [FB_W-1:0] fb_data;
   logic            sclk;
   logic            sdata;
   logic [COLS-1:0] col_en;
   logic            blank;
   logic            frame_start;

   int n_cmp = 0;
   int n_bad = 0;

   dmx_refresh_ctrl #(
      .NUM_CHARS (NC), .ROWS (ROWS), .COLS (COLS), .BYTE_W (8),
      .SYS_CLK_HZ (100_000_000), .SCLK_HALF (HALF), .ON_CYCLES (ONC),
      .PWM_PERIOD (PP), .PWM_HIGH (PH)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .fb_data (fb_data), .sclk (sclk),
      .sdata (sdata), .col_en (col_en), .blank (blank),
      .frame_start (frame_start)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [FB_W-1:0] pat(input int seed);
      logic [FB_W-1:0] v;
      for (int s = 0; s < NC * COLS; s++) begin
         if (seed == 0)      v[s*8 +: 8] = 8'h00;
         else if (seed == 1) v[s*8 +: 8] = 8'hFF;
         else                v[s*8 +: 8] = 8'(s * 37 + seed * 101) ^ 8'h5A;
      end
      return v;
   endfunction

   // R3: expected chain contents after the load of column k
   function automatic logic [NBITS-1:0] exp_chain(input int k, input logic [FB_W-1:0] fb);
      logic [NBITS-1:0] e;
      for (int i = 0; i < NBITS; i++) begin
         int c = NC - 1 - i / ROWS;
         int r = ROWS - 1 - i % ROWS;
         e[NBITS-1-i] = fb[(c * COLS + k) * 8 + r];
      end
      return e;
   endfunction

   task automatic wait_next_frame();
      do @(negedge clk); while (!frame_start);
   endtask

   task automatic run_column(input int k, input logic [FB_W-1:0] fb);
      logic [NBITS-1:0] sr = '0;
      logic prev = sclk;
      logic held = 1'b0;
      int bits = 0, run = 1, bad_run = 0, bad_stab = 0, on = 0, bad_on = 0;
      bit seen_rise = 0;
      logic [COLS-1:0] onehot = COLS'(1) << k;
      forever begin
         @(negedge clk);
         if (col_en != '0) break;
         if (sclk != prev) begin
            if (prev || seen_rise) if (run != HALF) bad_run++;
            if (sclk) begin
               sr = {sr[NBITS-2:0], sdata};
               bits++;
               held = sdata;
               seen_rise = 1;
            end
            run = 1;
         end else run++;
         if (sclk && sdata != held) bad_stab++;
         prev = sclk;
      end
      chk(bits == NBITS, "R2", "shift edges before strobe", 64'(bits), 64'(NBITS));
      chk(bad_run == 0, "R5", "sclk phase length errors", 64'(bad_run), 64'd0);
      chk(bad_stab == 0, "R4", "sdata changes while sclk high", 64'(bad_stab), 64'd0);
      chk(col_en == onehot, "R6", "enabled column", 64'(col_en), 64'(onehot));
      chk(sr == exp_chain(k, fb), "R3", "captured chain", 64'(sr), 64'(exp_chain(k, fb)));
      while (col_en == onehot) begin
         if (sclk) bad_on++;
         on++;
         @(negedge clk);
      end
      chk(on == ONC, "R7", "column on-time", 64'(on), 64'(ONC));
      chk(bad_on == 0, "R2", "sclk toggles while column on", 64'(bad_on), 64'd0);
      chk(col_en == '0, "R6", "gap after column", 64'(col_en), 64'd0);
   endtask

   task automatic run_frame(input logic [FB_W-1:0] fb);
      chk(frame_start && col_en == '0 && !sclk, "R8", "frame marker context",
          {62'd0, frame_start, sclk}, 64'd2);
      for (int k = 0; k < COLS; k++) run_column(k, fb);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      fb_data = pat(2);
      repeat (3) @(negedge clk);
      chk({sclk, sdata, col_en, blank, frame_start} == '0, "R1", "outputs in reset",
          64'({sclk, sdata, col_en, blank, frame_start}), 64'd0);
      rst_n = 1'b1;
      wait_next_frame();
      @(negedge clk);
      chk(!frame_start, "R8", "frame marker width", 64'(frame_start), 64'd0);
   endtask

   task automatic t_pattern(input int seed);
      fb_data = pat(seed);
      wait_next_frame();
      run_frame(pat(seed));
   endtask

   task automatic t_reset_restart();
      while (col_en != 5'b00100) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({sclk, sdata, col_en, blank, frame_start} == '0, "R1", "outputs after mid-run reset",
          64'({sclk, sdata, col_en, blank, frame_start}), 64'd0);
      fb_data = pat(3);
      @(negedge clk);
      rst_n = 1'b1;
      wait_next_frame();
      run_frame(pat(3));   // R1: restart begins at column 1
   endtask

   task automatic t_tear();
      fb_data = pat(4);
      wait_next_frame();
      chk(frame_start, "R8", "marker present", 64'(frame_start), 64'd1);
      run_column(0, pat(4));
      fb_data = pat(5);     // R8: mid-frame change must not show yet
      for (int k = 1; k < COLS; k++) run_column(k, pat(4));
      chk(frame_start, "R8", "marker at next frame", 64'(frame_start), 64'd1);
      run_frame(pat(5));
   endtask

   task automatic t_pwm();
      int hi = 0, lo = 0;
      @(negedge clk);
      while (blank) @(negedge clk);
      while (!blank) @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         hi = 0; lo = 0;
         while (blank)  begin hi++; @(negedge clk); end
         while (!blank) begin lo++; @(negedge clk); end
         chk(hi == PH, "R9", "blank high length", 64'(hi), 64'(PH));
         chk(hi + lo == PP, "R9", "blank period", 64'(hi + lo), 64'(PP));
      end
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_pattern(1);
      t_pattern(0);
      t_pattern(2);
      t_reset_restart();
      t_tear();
      t_pwm();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule